// File: doc/BRIEF.md
# Binary-Field Inverter with Unrolled Step Chain

This block returns the multiplicative inverse of a nonzero element of GF(2^M), where elements are bit vectors in polynomial basis and bit i is the coefficient of x^i. It runs a modified almost-inverse iteration on four state values. The working pair `u` and `v` starts as the operand and the field polynomial. The companion pair `b` and `c` starts as 1 and 0. Every elementary step does one of two things. If `u` is even, it halves `u` and divides `b` by x modulo the field polynomial. If `u` is odd, it adds the pair of lower degree into the other, first swapping the pairs when `u` has the smaller degree. The run ends when `u` reaches 1, and `b` then holds the inverse.

A chain of `UNROLL` elementary steps sits between the state registers. Each clock therefore retires up to `UNROLL` iterations. The chain is built only from XORs, one-position shifts and multiplexed swaps. The degrees of `u` and `v` are carried in small counters beside the data, so the odd/even choice and the swap test come from a counter compare. A step that receives `u = 1` passes its inputs through unchanged, so a run can finish part-way along the chain.

A caller pulses `start` with the operand. It then waits for the one-cycle `done` pulse and reads `result`, which stays put until the next accepted start. A zero operand has no inverse: it completes at once with `err` raised.

Top module: `gf2m_inverter`

## Requirements
- R1: For every nonzero operand a, `result` times a, reduced modulo the field polynomial, equals 1.
- R2: The legal values of `UNROLL` are 1, 2 and 4. All three give bit-identical results for every operand, including runs whose step count is not a multiple of the unroll factor.
- R3: Each running clock retires up to `UNROLL` steps. For operand 1, `done` is high in the first cycle after the start edge. For the same operand, latency does not increase as `UNROLL` grows.
- R4: For the all-ones operand, twice the latency with `UNROLL` = 4 is at most the latency with `UNROLL` = 1 plus 2 cycles.
- R5: After reset, `busy` and `done` are 0. `busy` is high from the cycle after an accepted start through the `done` cycle. `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R6: While idle, `result` does not change, whatever happens on `operand`, until a new start is accepted.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The running computation completes and returns the inverse of the first operand.
- R8: For a zero operand, `done` and `err` are high in the first cycle after the start edge and `result` is 0. `err` is never high for a nonzero operand, and `err` is high only together with `done`.
- R9: The field polynomial is x^M + x^TAP + 1, with defaults M = 89 and TAP = 38. For example, the inverse of x is then x^88 + x^37. The configuration M = 113 with TAP = 9 also yields correct inverses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an inversion of `operand`; accepted only when idle |
| operand | input | M | Field element to invert |
| busy | output | 1 | Computation in progress, through the `done` cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | High with `done` when the operand was zero |
| result | output | M | Inverse of the last accepted operand (0 on error) |

## Verification
Two events can share one clock. The first is termination: `u` reaches 1 at an inner stage of the chain. The second is the work of the remaining stages in that same clock, which must then pass the state through untouched. The bench provokes this by running the same table, random and corner operands on instances with unroll factors 1, 2 and 4. Most operands need a step count that is not a multiple of 2 or 4, so the faster instances stop mid-chain. Correct handling is judged by requiring the three results to be bit-identical and each one to multiply back to 1 under an independent bit-serial modular multiply.

// File: rtl/gf_inv_pkg.sv
package gf_inv_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operand and initial state
    logic run;   // advance the state through the step chain
  } invCmd_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } invState_t;

endpackage

// File: rtl/gf_inv_msb.sv
// index of the highest set bit (0 for an all-zero input)
module gf_inv_msb #(
  parameter int W  = 90,
  parameter int DW = $clog2(W)
) (
  input  logic [W-1:0]  x,
  output logic [DW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (x[i]) idx = DW'(i);
    end
  end
endmodule

// File: rtl/gf_inv_step.sv
// one elementary iteration; holds when u == 1 (degree 0)
module gf_inv_step #(
  parameter int         M    = 89,
  parameter int         DW   = 7,
  parameter logic [M:0] POLY = '1
) (
  input  logic [M:0]    uIn,
  input  logic [M:0]    vIn,
  input  logic [M-1:0]  bIn,
  input  logic [M-1:0]  cIn,
  input  logic [DW-1:0] duIn,
  input  logic [DW-1:0] dvIn,
  output logic [M:0]    uOut,
  output logic [M:0]    vOut,
  output logic [M-1:0]  bOut,
  output logic [M-1:0]  cOut,
  output logic [DW-1:0] duOut,
  output logic [DW-1:0] dvOut
);
  logic [M:0]    sumU;
  logic [M-1:0]  sumB;
  logic [M-1:0]  bHalf;
  logic [DW-1:0] sumDeg;

  assign sumU  = uIn ^ vIn;
  assign sumB  = bIn ^ cIn;
  // b / x mod f: add f when b is odd, then drop bit 0 (f has bit M set)
  assign bHalf = {bIn[0], bIn[M-1:1] ^ (POLY[M-1:1] & {(M-1){bIn[0]}})};

  gf_inv_msb #(.W(M+1), .DW(DW)) u_msb (.x(sumU), .idx(sumDeg));

  always_comb begin
    uOut  = uIn;
    vOut  = vIn;
    bOut  = bIn;
    cOut  = cIn;
    duOut = duIn;
    dvOut = dvIn;
    if (duIn != '0) begin
      if (!uIn[0]) begin
        uOut  = uIn >> 1;
        bOut  = bHalf;
        duOut = duIn - DW'(1);
      end else if (duIn < dvIn) begin
        // swap pairs, then add: the sum keeps the larger degree
        uOut  = sumU;
        bOut  = sumB;
        vOut  = uIn;
        cOut  = bIn;
        duOut = dvIn;
        dvOut = duIn;
      end else begin
        uOut  = sumU;
        bOut  = sumB;
        duOut = (duIn == dvIn) ? sumDeg : duIn;
      end
    end
  end
endmodule

// File: rtl/gf_inv_datapath.sv
module gf_inv_datapath
  import gf_inv_pkg::*;
#(
  parameter int         M      = 89,
  parameter int         UNROLL = 4,
  parameter int         DW     = 7,
  parameter logic [M:0] POLY   = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  invCmd_t      cmd,
  input  logic [M-1:0] operand,
  output logic [M-1:0] result,
  output logic         uOne,
  output logic         zeroFlag
);
  logic [M:0]    uReg, vReg;
  logic [M-1:0]  bReg, cReg;
  logic [DW-1:0] duReg, dvReg;
  logic          zeroReg;
  logic [DW-1:0] loadDeg;

  logic [M:0]    uC  [UNROLL+1];
  logic [M:0]    vC  [UNROLL+1];
  logic [M-1:0]  bC  [UNROLL+1];
  logic [M-1:0]  cC  [UNROLL+1];
  logic [DW-1:0] duC [UNROLL+1];
  logic [DW-1:0] dvC [UNROLL+1];

  gf_inv_msb #(.W(M+1), .DW(DW)) u_loadMsb (.x({1'b0, operand}), .idx(loadDeg));

  assign uC[0]  = uReg;
  assign vC[0]  = vReg;
  assign bC[0]  = bReg;
  assign cC[0]  = cReg;
  assign duC[0] = duReg;
  assign dvC[0] = dvReg;

  for (genvar k = 0; k < UNROLL; k++) begin : g_chain
    gf_inv_step #(.M(M), .DW(DW), .POLY(POLY)) u_step (
      .uIn (uC[k]),  .vIn (vC[k]),  .bIn (bC[k]),  .cIn (cC[k]),
      .duIn(duC[k]), .dvIn(dvC[k]),
      .uOut(uC[k+1]), .vOut(vC[k+1]), .bOut(bC[k+1]), .cOut(cC[k+1]),
      .duOut(duC[k+1]), .dvOut(dvC[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uReg    <= '0;
      vReg    <= '0;
      bReg    <= '0;
      cReg    <= '0;
      duReg   <= '0;
      dvReg   <= '0;
      zeroReg <= 1'b0;
    end else if (cmd.load) begin
      uReg    <= {1'b0, operand};
      vReg    <= POLY;
      bReg    <= (operand == '0) ? '0 : M'(1);
      cReg    <= '0;
      duReg   <= loadDeg;
      dvReg   <= DW'(M);
      zeroReg <= (operand == '0);
    end else if (cmd.run) begin
      uReg    <= uC[UNROLL];
      vReg    <= vC[UNROLL];
      bReg    <= bC[UNROLL];
      cReg    <= cC[UNROLL];
      duReg   <= duC[UNROLL];
      dvReg   <= dvC[UNROLL];
    end
  end

  // nonzero u of degree 0 is exactly 1
  assign uOne     = (duReg == '0) && !zeroReg;
  assign zeroFlag = zeroReg;
  assign result   = bReg;
endmodule

// File: rtl/gf_inv_ctrl.sv
module gf_inv_ctrl
  import gf_inv_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    uOne,
  input  logic    zeroFlag,
  output invCmd_t cmd,
  output logic    busy,
  output logic    done,
  output logic    err
);
  invState_t state, stateNext;
  logic      finish;

  always_comb begin
    finish    = (state == ST_RUN) && (uOne || zeroFlag);
    cmd.load  = (state == ST_IDLE) && start;
    cmd.run   = (state == ST_RUN) && !finish;
    stateNext = state;
    if (cmd.load) stateNext = ST_RUN;
    else if (finish) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_RUN);
  assign done = finish;
  assign err  = finish && zeroFlag;
endmodule

// File: rtl/gf2m_inverter.sv
module gf2m_inverter
  import gf_inv_pkg::*;
#(
  parameter int M      = 89,
  parameter int TAP    = 38,
  parameter int UNROLL = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [M-1:0] operand,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [M-1:0] result
);
  localparam int         DW   = $clog2(M + 1);
  localparam logic [M:0] ONE  = {{M{1'b0}}, 1'b1};
  localparam logic [M:0] POLY = (ONE << M) | (ONE << TAP) | ONE;

  invCmd_t cmd;
  logic    uOne, zeroFlag;

  gf_inv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .uOne(uOne), .zeroFlag(zeroFlag),
    .cmd(cmd), .busy(busy), .done(done), .err(err)
  );

  gf_inv_datapath #(.M(M), .UNROLL(UNROLL), .DW(DW), .POLY(POLY)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .operand(operand),
    .result(result), .uOne(uOne), .zeroFlag(zeroFlag)
  );
endmodule

// File: rtl/gf2m_inverter_chk.sv
module gf2m_inverter_chk #(
  parameter int M = 89
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         err,
  input logic [M-1:0] result
);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_in_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  assert_idle_after_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(result));

  assert_keep_running_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  assert_start_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);
endmodule

bind gf2m_inverter gf2m_inverter_chk #(.M(M)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .done(done), .err(err), .result(result)
);

// File: tb/sim_gf2m_inverter.sv
module sim_gf2m_inverter;
  localparam logic [127:0] F89  = (128'h1 << 89) | (128'h1 << 38) | 128'h1;
  localparam logic [127:0] F113 = (128'h1 << 113) | (128'h1 << 9) | 128'h1;
  localparam logic [88:0]  ONES = {89{1'b1}};

  typedef struct packed {
    logic [88:0] op;
    logic [88:0] exp;
    logic        hasExp;
  } vec_t;

  localparam vec_t TAB [8] = '{
    '{89'h1, 89'h1, 1'b1},
    '{89'h2, (89'h1 << 88) | (89'h1 << 37), 1'b1},
    '{ONES, 89'h0, 1'b0},
    '{89'h1 << 88, 89'h0, 1'b0},
    '{89'h3, 89'h0, 1'b0},
    '{89'h1_2345_6789_ABCD_EF01_2345_67, 89'h0, 1'b0},
    '{89'h0F0F_F0F0_0000_1111_0001, 89'h0, 1'b0},
    '{89'h1 << 38, 89'h0, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [88:0]  operand = '0;
  logic [112:0] operandBig = '0;
  logic [2:0]   doneV, busyV, errV;
  logic [88:0]  resV [3];
  logic         doneBig, busyBig, errBig;
  logic [112:0] resBig;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gf2m_inverter #(.M(89), .TAP(38), .UNROLL(1)) u1 (
    .clk(clk), .rstN(rstN), .start(start), .operand(operand),
    .busy(busyV[0]), .done(doneV[0]), .err(errV[0]), .result(resV[0]));
  gf2m_inverter #(.M(89), .TAP(38), .UNROLL(2)) u2 (
    .clk(clk), .rstN(rstN), .start(start), .operand(operand),
    .busy(busyV[1]), .done(doneV[1]), .err(errV[1]), .result(resV[1]));
  gf2m_inverter #(.M(89), .TAP(38), .UNROLL(4)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .operand(operand),
    .busy(busyV[2]), .done(doneV[2]), .err(errV[2]), .result(resV[2]));
  gf2m_inverter #(.M(113), .TAP(9), .UNROLL(4)) u3 (
    .clk(clk), .rstN(rstN), .start(start), .operand(operandBig),
    .busy(busyBig), .done(doneBig), .err(errBig), .result(resBig));

  // bit-serial a*b mod poly, poly includes bit m
  function automatic logic [127:0] mulMod(input logic [127:0] a, input logic [127:0] b,
                                          input int m, input logic [127:0] poly);
    logic [127:0] r = '0;
    for (int i = 127; i >= 0; i--) begin
      if (i < m) begin
        r = r << 1;
        if (r[m]) r = r ^ poly;
        if (b[i]) r = r ^ a;
      end
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // captured per run: index 0..2 = unroll 1,2,4 ; index 3 = wide field
  int          lat [4];
  int          pulses [4];
  logic [3:0]  got;
  logic [88:0] res [3];
  logic [2:0]  errS;
  logic [112:0] resB;

  task automatic runOp(input logic [88:0] op, input int injAt, input logic [88:0] injOp);
    int cyc = 0;
    int maxLat = 0;
    got = '0;
    for (int j = 0; j < 4; j++) begin lat[j] = 0; pulses[j] = 0; end
    @(negedge clk);
    operand = op;
    operandBig = {24'hC3A5E1, op};
    start = 1'b1;
    while (!((&got) && cyc >= maxLat + 3) && cyc < 700) begin
      @(negedge clk);
      cyc++;
      for (int j = 0; j < 3; j++) begin
        if (doneV[j]) begin
          pulses[j]++;
          if (!got[j]) begin got[j] = 1'b1; lat[j] = cyc; res[j] = resV[j]; errS[j] = errV[j]; end
        end
      end
      if (doneBig) begin
        pulses[3]++;
        if (!got[3]) begin got[3] = 1'b1; lat[3] = cyc; resB = resBig; end
      end
      start = (cyc == injAt);
      if (cyc == injAt) operand = injOp;
      for (int j = 0; j < 4; j++) if (got[j] && lat[j] > maxLat) maxLat = lat[j];
    end
    start = 1'b0;
    chk(&got, "R5 completion", 128'(got), 128'hF);
  endtask

  task automatic evalOp(input logic [88:0] op, input logic hasExp, input logic [88:0] exp);
    for (int j = 0; j < 3; j++) begin
      if (op == '0) begin
        chk(errS[j] && res[j] == '0, "R8 zero operand", 128'(res[j]), 128'h0);
      end else begin
        chk(!errS[j], "R8 no err on nonzero", 128'(errS[j]), 128'h0);
        chk(mulMod(128'(op), 128'(res[j]), 89, F89) == 128'h1, "R1 product",
            mulMod(128'(op), 128'(res[j]), 89, F89), 128'h1);
      end
      chk(pulses[j] == 1, "R5 single done pulse", 128'(pulses[j]), 128'h1);
    end
    chk(res[0] == res[1] && res[1] == res[2], "R2 unroll agreement",
        128'(res[2]), 128'(res[0]));
    chk(lat[2] <= lat[1] && lat[1] <= lat[0], "R3 latency order",
        128'(lat[2]), 128'(lat[0]));
    if (hasExp) chk(res[2] == exp, "R9 known inverse", 128'(res[2]), 128'(exp));
    chk(mulMod(128'({24'hC3A5E1, op}), 128'(resB), 113, F113) == 128'h1, "R9 wide field",
        mulMod(128'({24'hC3A5E1, op}), 128'(resB), 113, F113), 128'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5 reset state
    chk(busyV == '0 && doneV == '0 && !busyBig && !doneBig, "R5 reset state",
        128'({busyV, doneV}), 128'h0);

    // R1 R2 R9: table walk
    for (int t = 0; t < 8; t++) begin
      runOp(TAB[t].op, 0, '0);
      evalOp(TAB[t].op, TAB[t].hasExp, TAB[t].exp);
    end

    // R1 R2: random operands
    for (int t = 0; t < 6; t++) begin
      logic [88:0] r;
      r = {$urandom(), $urandom(), $urandom()};
      if (r == '0) r = 89'h5;
      runOp(r, 0, '0);
      evalOp(r, 1'b0, '0);
    end

    // R3: operand 1 completes in the first cycle
    runOp(89'h1, 0, '0);
    for (int j = 0; j < 3; j++) chk(lat[j] == 1, "R3 operand one latency", 128'(lat[j]), 128'h1);

    // R8: zero operand
    runOp(89'h0, 0, '0);
    evalOp(89'h0, 1'b0, '0);
    for (int j = 0; j < 3; j++) chk(lat[j] == 1, "R8 zero latency", 128'(lat[j]), 128'h1);

    // R4: unroll speedup on all-ones
    runOp(ONES, 0, '0);
    evalOp(ONES, 1'b0, '0);
    chk(2 * lat[2] <= lat[0] + 2, "R4 speedup", 128'(lat[2]), 128'(lat[0]));

    // R6: result holds while idle with a changing operand
    repeat (3) @(negedge clk);
    operand = 89'h3;
    repeat (4) @(negedge clk);
    for (int j = 0; j < 3; j++) chk(resV[j] == res[j], "R6 result hold", 128'(resV[j]), 128'(res[j]));

    // R7: start while busy is ignored
    runOp(ONES, 2, 89'h2);
    for (int j = 0; j < 3; j++)
      chk(mulMod(128'(ONES), 128'(res[j]), 89, F89) == 128'h1, "R7 start ignored",
          mulMod(128'(ONES), 128'(res[j]), 89, F89), 128'h1);
    for (int j = 0; j < 3; j++) chk(pulses[j] == 1, "R7 one pulse", 128'(pulses[j]), 128'h1);

    // R5: idle after completion
    chk(busyV == '0 && doneV == '0, "R5 idle after done", 128'({busyV, doneV}), 128'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule